// File: doc/BRIEF.md
# Hit Pattern Memory with Serial Drain

This block records discriminator activity from a bank of front-end channels during a bunch train. Each channel offers two comparator bits per bunch crossing, one for a low and one for a high threshold. On every bunch tick inside the acquisition window the block checks whether any of those bits is set. Only crossings with a hit are stored. Each stored frame holds the complete two-bit pattern of all channels, the current crossing number and a header byte that carries a chip identifier.

After the train, the stored frames are shifted out on one serial line in the order they were written. The bit rate is chosen from two settings, each expressed as a number of system clocks per bit. The memory is written only during acquisition and read only outside it. This suits a duty-cycled system in which many chips take turns on a shared readout line.

Top module: `hit_frame_store`

## Requirements
- R1: After reset, ser_out, ro_busy, ro_done and mem_full are 0 and frame_count is 0.
- R2: A frame is stored on a bunch tick inside the acquisition window exactly when at least one of the 2*NCH discriminator bits is 1. Each stored frame raises frame_count by one. A tick with no bit set stores nothing.
- R3: A frame is 160 bits wide. Bits 159:152 hold the chip_id value present at capture. Bits 151:128 hold the crossing number. Channel i puts disc_a[i] at bit 2i and disc_b[i] at bit 2i+1.
- R4: In the first cycle that acq_en is high, the crossing counter is cleared and any bx_tick in that cycle is ignored. After that, every bx_tick while acq_en is high adds one to the counter, whether or not a hit is present. A stored frame carries the number of ticks counted before it in the current acquisition.
- R5: Once DEPTH frames are stored, mem_full is 1. Further hits are dropped and frame_count stays at DEPTH.
- R6: A ro_start pulse while acq_en is low and ro_busy is low starts a readout. The frames go out in write order, each sent from bit 159 down to bit 0 on ser_out, and ro_busy is high throughout.
- R7: Each bit is held for SLOW_DIV clock cycles when rate_fast is 0 at start, and for FAST_DIV cycles when it is 1. The first bit appears in the cycle after ro_start is taken.
- R8: When the last bit period ends, ro_busy falls and ro_done is high for exactly one cycle. If no frame is stored, ro_start gives a single ro_done pulse in the next cycle and ro_busy stays low.
- R9: ro_start has no effect while acq_en is high.
- R10: The start of a new acquisition clears frame_count and mem_full.
- R11: ser_out is 0 whenever ro_busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_en | input | 1 | Acquisition window, high during the bunch train |
| bx_tick | input | 1 | One-cycle strobe per bunch crossing |
| disc_a | input | NCH (64) | Low-threshold comparator bit of each channel |
| disc_b | input | NCH (64) | High-threshold comparator bit of each channel |
| chip_id | input | HDRW (8) | Identifier placed in each frame header |
| ro_start | input | 1 | Readout request pulse |
| rate_fast | input | 1 | Selects FAST_DIV (1) or SLOW_DIV (0) clocks per bit |
| mem_full | output | 1 | All frame slots used |
| frame_count | output | clog2(DEPTH+1) (8) | Number of frames stored |
| ro_busy | output | 1 | Serial stream in progress |
| ro_done | output | 1 | One-cycle pulse at the end of readout |
| ser_out | output | 1 | Serial data, MSB of each frame first |

## Verification
The assertions assume that acq_en stays low for the whole of a readout, so that the memory is never written while it is being drained. The stimulus raises acq_en only while ro_busy is low. It issues a ro_start during acquisition only to check that the request is refused. Discriminator bits and bx_tick change on the falling clock edge, so each tick is seen by exactly one rising edge. The channel-bit sweep walks a single set bit through all 128 pattern positions, four frames per acquisition, and each frame's expected image is computed from the tick count and the chip identifier.

// File: rtl/hit_frame_store.sv
module hit_frame_store #(
  parameter int NCH      = 64,
  parameter int DEPTH    = 128,
  parameter int BCW      = 24,
  parameter int HDRW     = 8,
  parameter int SLOW_DIV = 250,
  parameter int FAST_DIV = 50
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acq_en,
  input  logic                       bx_tick,
  input  logic [NCH-1:0]             disc_a,
  input  logic [NCH-1:0]             disc_b,
  input  logic [HDRW-1:0]            chip_id,
  input  logic                       ro_start,
  input  logic                       rate_fast,
  output logic                       mem_full,
  output logic [$clog2(DEPTH+1)-1:0] frame_count,
  output logic                       ro_busy,
  output logic                       ro_done,
  output logic                       ser_out
);

  localparam int FW   = HDRW + BCW + 2*NCH;
  localparam int PW   = $clog2(DEPTH+1);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int MAXD = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int DW   = $clog2(MAXD+1);
  localparam int BW   = $clog2(FW);

  logic [2*NCH-1:0] pattern;
  logic [BCW-1:0]   bcid;
  logic [PW-1:0]    wr_cnt, rd_ptr;
  logic [BW-1:0]    bit_cnt;
  logic [DW-1:0]    div_cnt, div_last;
  logic [FW-1:0]    sh;
  logic [FW-1:0]    mem [DEPTH];
  logic             acq_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ilv
    assign pattern[2*i]   = disc_a[i];
    assign pattern[2*i+1] = disc_b[i];
  end

  wire acq_rise = acq_en & ~acq_q;
  wire tick_ok  = acq_en & ~acq_rise & bx_tick;
  wire wr_fire  = tick_ok & (|pattern) & ~mem_full;
  wire go       = ro_start & ~acq_en & ~ro_busy;
  wire bit_end  = ro_busy & (div_cnt == div_last);
  wire frm_end  = bit_end & (bit_cnt == BW'(FW-1));

  assign mem_full    = (wr_cnt == PW'(DEPTH));
  assign frame_count = wr_cnt;
  assign ser_out     = sh[FW-1];

  always_ff @(posedge clk)
    if (wr_fire) mem[wr_cnt[AW-1:0]] <= {chip_id, bcid, pattern};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acq_q  <= 1'b0;
      bcid   <= '0;
      wr_cnt <= '0;
    end else begin
      acq_q <= acq_en;
      if (acq_rise) begin
        bcid   <= '0;
        wr_cnt <= '0;
      end else begin
        if (tick_ok) bcid <= bcid + 1'b1;
        if (wr_fire) wr_cnt <= wr_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ro_busy  <= 1'b0;
      ro_done  <= 1'b0;
      rd_ptr   <= '0;
      bit_cnt  <= '0;
      div_cnt  <= '0;
      div_last <= '0;
      sh       <= '0;
    end else begin
      ro_done <= 1'b0;
      if (go) begin
        if (wr_cnt == '0) begin
          ro_done <= 1'b1;
        end else begin
          ro_busy  <= 1'b1;
          sh       <= mem[0];
          rd_ptr   <= PW'(1);
          bit_cnt  <= '0;
          div_cnt  <= '0;
          div_last <= rate_fast ? DW'(FAST_DIV-1) : DW'(SLOW_DIV-1);
        end
      end else if (ro_busy) begin
        if (!bit_end) begin
          div_cnt <= div_cnt + 1'b1;
        end else begin
          div_cnt <= '0;
          if (!frm_end) begin
            sh      <= sh << 1;
            bit_cnt <= bit_cnt + 1'b1;
          end else begin
            bit_cnt <= '0;
            if (rd_ptr == wr_cnt) begin
              ro_busy <= 1'b0;
              ro_done <= 1'b1;
              sh      <= '0;
            end else begin
              sh     <= mem[rd_ptr[AW-1:0]];
              rd_ptr <= rd_ptr + 1'b1;
            end
          end
        end
      end
    end
  end

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_count <= PW'(DEPTH));

  assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_full && !acq_rise) |=> frame_count == $past(frame_count));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_rise |=> (frame_count == $past(frame_count) ||
                   frame_count == $past(frame_count) + 1'b1));

  assert_idle_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ro_busy |-> !ser_out);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ro_done |=> !ro_done);

  assert_no_acq_in_readout_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ro_busy |-> !acq_en);

  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ro_busy) |-> ro_done);

endmodule

// File: tb/test_hit_frame_store.sv
module test_hit_frame_store;
  localparam int NCH = 64, DEPTH = 4, SLOWD = 3, FASTD = 1, FW = 160;

  logic clk = 0, rst_n = 0, acq_en = 0, bx_tick = 0, ro_start = 0, rate_fast = 0;
  logic [NCH-1:0] disc_a = '0, disc_b = '0;
  logic [7:0] chip_id = 8'hC3;
  logic mem_full, ro_busy, ro_done, ser_out;
  logic [2:0] frame_count;

  always #2 clk = ~clk;

  hit_frame_store #(.NCH(NCH), .DEPTH(DEPTH), .BCW(24), .HDRW(8),
                    .SLOW_DIV(SLOWD), .FAST_DIV(FASTD)) i_hit_frame_store (
    .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .bx_tick(bx_tick),
    .disc_a(disc_a), .disc_b(disc_b), .chip_id(chip_id), .ro_start(ro_start),
    .rate_fast(rate_fast), .mem_full(mem_full), .frame_count(frame_count),
    .ro_busy(ro_busy), .ro_done(ro_done), .ser_out(ser_out));

  int checks = 0, errors = 0;
  logic [FW-1:0] exp_f [8];
  int n_exp = 0;
  int bc = 0;

  task automatic chk(input bit ok, input string req, input logic [FW-1:0] got, input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [127:0] ilv(input logic [NCH-1:0] a, input logic [NCH-1:0] b);
    logic [127:0] p;
    for (int i = 0; i < NCH; i++) begin
      p[2*i] = a[i];
      p[2*i+1] = b[i];
    end
    return p;
  endfunction

  task automatic begin_acq(input logic [NCH-1:0] a, input logic [NCH-1:0] b);
    acq_en = 1; bx_tick = 1; disc_a = a; disc_b = b;
    @(negedge clk);
    bx_tick = 0; disc_a = '0; disc_b = '0;
    n_exp = 0; bc = 0;
  endtask

  task automatic bx(input logic [NCH-1:0] a, input logic [NCH-1:0] b);
    bx_tick = 1; disc_a = a; disc_b = b;
    if (((|a) || (|b)) && n_exp < DEPTH) begin
      exp_f[n_exp] = {chip_id, 24'(bc), ilv(a, b)};
      n_exp++;
    end
    bc++;
    @(negedge clk);
    bx_tick = 0; disc_a = '0; disc_b = '0;
    @(negedge clk);
  endtask

  task automatic end_acq;
    acq_en = 0;
    @(negedge clk);
  endtask

  task automatic readout(input logic fast, input string tag);
    int dv;
    logic [FW-1:0] got;
    bit steady, busy_ok;
    dv = fast ? FASTD : SLOWD;
    rate_fast = fast; ro_start = 1;
    @(negedge clk);
    ro_start = 0;
    for (int f = 0; f < n_exp; f++) begin
      got = '0; steady = 1; busy_ok = 1;
      for (int j = 0; j < FW; j++) begin
        for (int d = 0; d < dv; d++) begin
          if (d == 0) got[FW-1-j] = ser_out;
          else if (ser_out !== got[FW-1-j]) steady = 0;
          if (ro_busy !== 1'b1) busy_ok = 0;
          @(negedge clk);
        end
      end
      chk(got === exp_f[f], {"R3 R6 frame ", tag}, got, exp_f[f]);
      chk(steady && busy_ok, {"R7 bit period ", tag}, FW'(steady), FW'(1));
    end
    chk(ro_busy === 1'b0 && ro_done === 1'b1, {"R8 end ", tag}, FW'({ro_busy, ro_done}), FW'(2'b01));
    chk(ser_out === 1'b0, {"R11 idle ", tag}, FW'(ser_out), FW'(0));
    @(negedge clk);
    chk(ro_done === 1'b0, {"R8 pulse ", tag}, FW'(ro_done), FW'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ser_out === 0 && ro_busy === 0 && ro_done === 0 && mem_full === 0 && frame_count === 0,
        "R1 reset", FW'({ser_out, ro_busy, ro_done, mem_full, frame_count}), FW'(0));

    // R4: tick with a hit in the first acquisition cycle is ignored
    begin_acq(64'hFFFF, '0);
    chk(frame_count === 0, "R4 rise tick", FW'(frame_count), FW'(0));
    bx('0, '0);
    chk(frame_count === 0, "R2 no hit", FW'(frame_count), FW'(0));
    bx(64'h8000_0000_0000_0001, 64'h0123_4567_89AB_CDEF);
    bx('0, '0);
    bx('0, 64'h8000_0000_0000_0000);
    bx(64'h1, '0);
    chk(frame_count === 3 && mem_full === 0, "R2 count", FW'(frame_count), FW'(3));
    // R9: request during acquisition refused
    ro_start = 1;
    @(negedge clk);
    ro_start = 0;
    @(negedge clk);
    chk(ro_busy === 0 && ro_done === 0, "R9 start in acq", FW'({ro_busy, ro_done}), FW'(0));
    end_acq();
    readout(1'b0, "slow");

    // R5: overflow with a new chip id
    chip_id = 8'h5A;
    begin_acq('0, '0);
    for (int k = 0; k < 7; k++) bx(64'(k + 1), 64'(k) << 40);
    chk(frame_count === 3'(DEPTH) && mem_full === 1, "R5 full", FW'({mem_full, frame_count}), FW'({1'b1, 3'(DEPTH)}));
    end_acq();
    readout(1'b1, "fast");

    // R10: new acquisition clears, R8: empty readout
    begin_acq('0, '0);
    bx('0, '0);
    chk(frame_count === 0 && mem_full === 0, "R10 clear", FW'({mem_full, frame_count}), FW'(0));
    end_acq();
    ro_start = 1;
    @(negedge clk);
    ro_start = 0;
    chk(ro_done === 1 && ro_busy === 0, "R8 empty", FW'({ro_busy, ro_done}), FW'(1));
    @(negedge clk);
    chk(ro_done === 0 && ro_busy === 0, "R8 empty pulse", FW'({ro_busy, ro_done}), FW'(0));

    // R3 sweep: a single set bit through every pattern position
    for (int g = 0; g < 32; g++) begin
      chip_id = 8'(g * 7 + 1);
      begin_acq('0, '0);
      for (int k = 0; k < 4; k++) begin
        int pos;
        logic [NCH-1:0] a, b;
        pos = 4 * g + k;
        a = '0; b = '0;
        if (pos % 2 == 0) a[pos/2] = 1'b1; else b[pos/2] = 1'b1;
        if (k == 2) bx('0, '0);
        bx(a, b);
      end
      end_acq();
      readout(1'b1, "sweep");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule